// File: doc/BRIEF.md
# Two-Phase Single-Pulse Inverter Gate Generator

This block drives the two switch legs of a single-phase inverter. A free-running phase counter marks out one fundamental period. Within it, the block emits one pulse on gate A, centred in the first half of the period. It emits an identical pulse on gate B, displaced by exactly half a period. A control word sets the pulse width: a wider pulse delivers more power to the load, and a width of zero turns the load off.

The period and the width are sampled only at the period boundary, or while the block is idle. A setting changed mid-period therefore never produces a clipped or repeated pulse. The width is limited so that a guard gap of GUARD clock cycles always separates the end of one gate pulse from the start of the other. A one-cycle strobe marks the first cycle of each period.

Top module: `inv_gate_gen`

## Requirements
- R1: While `rst` is high, or after a clock edge at which `en` was low, `gate_a`, `gate_b` and `period_start` are all low. The first clock edge with `en` high after an idle spell starts a period at count 0, so `period_start` is high in the following cycle.
- R2: The period length is 2·H cycles, where H = max(floor(`period_in`/2), GUARD+1). `period_start` is high for exactly one cycle per period, in the cycle where the count is 0. An odd `period_in` is rounded down to the next even length.
- R3: With effective width W and L = floor((H−W)/2), `gate_a` is high for exactly the counts L to L+W−1 of each period, and low for every other count.
- R4: `gate_b` is high for exactly the counts H+L to H+L+W−1, which is the `gate_a` pattern delayed by H cycles. `gate_b` is never high at count 0.
- R5: The effective width is W = min(`width_in`, H−GUARD). `gate_a` and `gate_b` are never high in the same cycle. At full width, each pulse is separated from the next by exactly GUARD low cycles.
- R6: `width_in` and `period_in` take effect only at the clock edge where the count wraps to 0, or while the block is idle. A change made mid-period leaves the rest of that period unchanged.
- R7: A width of 0 holds both gates low for the whole period, while `period_start` keeps its normal timing.
- R8: When `en` falls in the middle of a period, the outputs go low in the next cycle. Raising `en` again restarts the period from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the counter at 0 and the gates low |
| width_in | input | CNT_W | Requested pulse width in clock cycles |
| period_in | input | CNT_W | Requested fundamental period in clock cycles |
| gate_a | output | 1 | First-half gate pulse |
| gate_b | output | 1 | Second-half gate pulse |
| period_start | output | 1 | One-cycle strobe at count 0 |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8) and a guard of 2 cycles (GUARD = 2). With these values a period of a few dozen cycles can be checked cycle by cycle in full. The width clamp, the minimum half-period of 3, and odd and even half-periods (which change the centring offset) are all reached with small input values. Width and period changes are applied both at the period boundary and mid-period, so the latching point can be observed directly on the gates.

// File: rtl/inv_gate_pkg.sv
package inv_gate_pkg;

   // index of each gate leg inside the generate array
   localparam int unsigned LEG_A = 0;
   localparam int unsigned LEG_B = 1;
   localparam int unsigned NUM_LEGS = 2;

   // smallest half-period that still leaves a width of one cycle
   function automatic int unsigned min_half(input int unsigned guard);
      return guard + 1;
   endfunction

endpackage

// File: rtl/igg_setpoint_latch.sv
module igg_setpoint_latch #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned GUARD = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] width_in,
   input  logic [CNT_W-1:0] period_in,
   output logic [CNT_W-1:0] half_q,
   output logic [CNT_W-1:0] wid_q
);
   import inv_gate_pkg::*;

   localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(min_half(GUARD));
   localparam logic [CNT_W-1:0] GAP      = CNT_W'(GUARD);

   logic [CNT_W-1:0] half_raw;
   logic [CNT_W-1:0] half_new;
   logic [CNT_W-1:0] wid_max;
   logic [CNT_W-1:0] wid_new;

   // rounding down to an even period, with a floor on the half length
   always_comb begin
      half_raw = {1'b0, period_in[CNT_W-1:1]};
      half_new = (half_raw < MIN_HALF) ? MIN_HALF : half_raw;
      wid_max  = half_new - GAP;
      wid_new  = (width_in > wid_max) ? wid_max : width_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         half_q <= MIN_HALF;
         wid_q  <= '0;
      end else if (load) begin
         half_q <= half_new;
         wid_q  <= wid_new;
      end
   end

endmodule

// File: rtl/igg_phase_counter.sv
module igg_phase_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] half,
   output logic [CNT_W-1:0] cnt,
   output logic             active,
   output logic             load
);

   logic [CNT_W-1:0] last;
   logic             wrap;

   always_comb begin
      last = {half[CNT_W-2:0], 1'b0} - CNT_W'(1);
      wrap = active && (cnt == last);
      // setpoints are refreshed at the wrap edge and throughout idle
      load = !active || wrap;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (!active) begin
         cnt    <= '0;
         active <= 1'b1;
      end else if (wrap) begin
         cnt    <= '0;
      end else begin
         cnt    <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/igg_pulse_window.sv
module igg_pulse_window #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned LEG   = 0
) (
   input  logic             active,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] half,
   input  logic [CNT_W-1:0] wid,
   output logic             gate
);

   logic             in_half;
   logic [CNT_W-1:0] off;
   logic [CNT_W-1:0] lo;
   logic [CNT_W:0]   hi;

   generate
      if (LEG == 0) begin : g_first
         assign in_half = (cnt < half);
         assign off     = cnt;
      end else begin : g_second
         assign in_half = (cnt >= half);
         assign off     = cnt - half;
      end
   endgenerate

   // centre the pulse in its half: start offset, exclusive end
   always_comb begin
      lo   = (half - wid) >> 1;
      hi   = {1'b0, lo} + {1'b0, wid};
      gate = active && in_half && (off >= lo) && ({1'b0, off} < hi);
   end

endmodule

// File: rtl/inv_gate_gen.sv
module inv_gate_gen #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned GUARD = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] width_in,
   input  logic [CNT_W-1:0] period_in,
   output logic             gate_a,
   output logic             gate_b,
   output logic             period_start
);
   import inv_gate_pkg::*;

   localparam longint unsigned HALF_CAP = (64'd1 << (CNT_W - 1)) - 1;

   generate
      if (CNT_W < 4 || CNT_W > 31) begin : g_bad_width
         $error("inv_gate_gen: CNT_W must lie in 4..31");
      end
      if (GUARD < 1) begin : g_bad_guard
         $error("inv_gate_gen: GUARD must be at least 1");
      end
      if (longint'(min_half(GUARD)) > HALF_CAP) begin : g_bad_fit
         $error("inv_gate_gen: GUARD too large for CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]    cnt;
   logic [CNT_W-1:0]    half_q;
   logic [CNT_W-1:0]    wid_q;
   logic                active;
   logic                load;
   logic [NUM_LEGS-1:0] legs;

   igg_phase_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .half   (half_q),
      .cnt    (cnt),
      .active (active),
      .load   (load)
   );

   igg_setpoint_latch #(.CNT_W(CNT_W), .GUARD(GUARD)) u_set (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .width_in  (width_in),
      .period_in (period_in),
      .half_q    (half_q),
      .wid_q     (wid_q)
   );

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         igg_pulse_window #(.CNT_W(CNT_W), .LEG(g)) u_win (
            .active (active),
            .cnt    (cnt),
            .half   (half_q),
            .wid    (wid_q),
            .gate   (legs[g])
         );
      end
   endgenerate

   assign gate_a       = legs[LEG_A];
   assign gate_b       = legs[LEG_B];
   assign period_start = active && (cnt == '0);

endmodule

// File: rtl/igg_checker.sv
module igg_checker (
   input logic clk,
   input logic rst,
   input logic en,
   input logic gate_a,
   input logic gate_b,
   input logic period_start
);

   assert_gates_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
      !(gate_a && gate_b));

   assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!gate_a && !gate_b && !period_start));

   assert_restart_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      (en && !$past(en)) |=> period_start);

   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
      period_start |=> !period_start);

   assert_b_not_at_start_R4: assert property (@(posedge clk) disable iff (rst)
      period_start |-> !gate_b);

endmodule

bind inv_gate_gen igg_checker u_chk (
   .clk          (clk),
   .rst          (rst),
   .en           (en),
   .gate_a       (gate_a),
   .gate_b       (gate_b),
   .period_start (period_start)
);

// File: tb/tb_inv_gate_gen.sv
`timescale 1ns/1ps
module tb_inv_gate_gen;

   localparam int unsigned CW = 8;
   localparam int G = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en = 1'b0;
   logic [CW-1:0] width_in = '0;
   logic [CW-1:0] period_in = '0;
   logic          gate_a, gate_b, period_start;

   int checks = 0;
   int fails = 0;
   int cur_w = 0;
   int cur_h = 0;

   inv_gate_gen #(.CNT_W(CW), .GUARD(G)) dut (
      .clk(clk), .rst(rst), .en(en), .width_in(width_in), .period_in(period_in),
      .gate_a(gate_a), .gate_b(gate_b), .period_start(period_start)
   );

   always #10 clk = ~clk;

   function automatic int eff_h(input int p);
      int h = p / 2;
      return (h < G + 1) ? G + 1 : h;
   endfunction

   function automatic int eff_w(input int w, input int h);
      return (w > h - G) ? h - G : w;
   endfunction

   task automatic check3(input logic ea, input logic eb, input logic es,
                         input string tag, input int k);
      checks++;
      if (gate_a !== ea || gate_b !== eb || period_start !== es) begin
         fails++;
         $display("FAIL %s count %0d: a/b/strobe = %b%b%b expected %b%b%b",
                  tag, k, gate_a, gate_b, period_start, ea, eb, es);
      end
   endtask

   // checks counts from..upto-1; current negedge holds count 'from'
   task automatic check_cycles(input int w, input int h, input int from,
                               input int upto, input string tag);
      int lo = (h - w) / 2;
      for (int k = from; k < upto; k++) begin
         logic ea = (k < h) && (k >= lo) && (k < lo + w);
         logic eb = (k >= h) && (k - h >= lo) && (k - h < lo + w);
         check3(ea, eb, k == 0, tag, k);
         @(negedge clk);
      end
      if (upto == 2 * h) check3(gate_a && (lo == 0) && (w > 0), 1'b0, 1'b1,
                                "R2 strobe at wrap", 0);
   endtask

   // new setting applied at count 0: this period keeps the old one
   task automatic apply(input int w, input int p, input string tag);
      int nh = eff_h(p);
      width_in  = CW'(w);
      period_in = CW'(p);
      check_cycles(cur_w, cur_h, 0, 2 * cur_h, "R6 old setting kept");
      cur_h = nh;
      cur_w = eff_w(w, nh);
      check_cycles(cur_w, cur_h, 0, 2 * cur_h, tag);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check3(1'b0, 1'b0, 1'b0, "R1 in reset", 0);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check3(1'b0, 1'b0, 1'b0, "R1 idle", 0);
      end
   endtask

   task automatic t_basic();
      width_in  = CW'(10);
      period_in = CW'(40);
      en = 1'b1;
      @(negedge clk);
      cur_h = 20;
      cur_w = 10;
      check_cycles(cur_w, cur_h, 0, 40, "R1 R3 R4 first period");
      check_cycles(cur_w, cur_h, 0, 40, "R3 R4 second period");
   endtask

   task automatic t_disable();
      check_cycles(cur_w, cur_h, 0, cur_h + 8, "R8 before drop");
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check3(1'b0, 1'b0, 1'b0, "R8 dropped", i);
      end
      en = 1'b1;
      @(negedge clk);
      check_cycles(cur_w, cur_h, 0, 2 * cur_h, "R8 restart");
   endtask

   task automatic t_midchange();
      int old_w = cur_w;
      check_cycles(cur_w, cur_h, 0, 5, "R6 before change");
      width_in = CW'(4);
      check_cycles(old_w, cur_h, 5, 2 * cur_h, "R6 mid change ignored");
      cur_w = eff_w(4, cur_h);
      check_cycles(cur_w, cur_h, 0, 2 * cur_h, "R6 new width");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      apply(6, 31, "R3 odd period");
      apply(200, 20, "R5 clamp");
      apply(0, 24, "R7 zero width");
      apply(5, 1, "R2 minimum period");
      apply(9, 36, "R3 R4 even");
      t_midchange();
      t_disable();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule